// File: doc/BRIEF.md
# Selectable-Policy Significand Truncation Stage

This stage takes a normalised significand that still carries extra low-order guard bits, together with its biased exponent, and reduces it to the stored fraction width. A two-bit policy input chooses how the dropped bits are treated. Chopping throws them away. Jamming forces the kept least significant bit to one whenever anything non-zero was dropped. Round-off adds one at the kept lsb when the top dropped bit is set. Each policy has a different error bias, so the stage can be switched per operation.

When round-off carries out of the leading one, the stage shifts the result right by one place and increments the exponent. It flags overflow when that increment reaches the all-ones exponent code. It also flags inexact results. All results are registered and appear one clock after the accepted input. The fraction width, guard width and exponent width are parameters. The defaults are 23 fraction bits, 3 guard bits and 8 exponent bits.

Top module: `guard_trunc_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid`, `sig_out`, `exp_out`, `inexact` and `overflow` are all zero.
- R2: A sample presented with `in_valid` high at a rising edge produces its results and `out_valid` high after exactly that edge. `out_valid` is low after an edge where `in_valid` was low.
- R3: Policy code 0 (and the spare code 3, which behaves identically) chops: `sig_out` equals `sig_in` shifted right by the guard width, whatever the guard bits hold, and `exp_out` equals `exp_in`.
- R4: Policy code 1 (jamming) returns the kept bits unchanged if the guard bits are all zero. Otherwise it returns them with bit 0 forced to 1. `exp_out` equals `exp_in`.
- R5: Policy code 2 (round-off) adds one to the kept bits when the most significant guard bit is 1, and chops otherwise.
- R6: When round-off carries out of the leading bit (kept bits all ones, top guard bit 1), `sig_out` is the leading one followed by all-zero fraction bits, and `exp_out` is `exp_in` plus one.
- R7: When such a carry would make the exponent reach or pass the all-ones code, `exp_out` is all ones and `overflow` is 1. `overflow` is 0 in every other case.
- R8: `inexact` is 1 exactly when any guard bit of the accepted sample is non-zero, under every policy.
- R9: After an edge where `in_valid` is low, `sig_out`, `exp_out`, `inexact` and `overflow` keep their previous values, whatever the data inputs hold.
- R10: The leading bit of `sig_in` is bit FRAC_W+GUARD_W and the guard bits are the low GUARD_W bits. For a normalised input, `sig_out` bit FRAC_W is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the sample on the data inputs |
| mode | input | 2 | Policy: 0 chop, 1 jam, 2 round-off, 3 chop |
| sig_in | input | FRAC_W+GUARD_W+1 | Leading bit, fraction and guard bits |
| exp_in | input | EXP_W | Biased exponent of the sample |
| out_valid | output | 1 | Results below belong to an accepted sample |
| sig_out | output | FRAC_W+1 | Leading bit and truncated fraction |
| exp_out | output | EXP_W | Exponent after any renormalisation |
| inexact | output | 1 | Some guard bit was non-zero |
| overflow | output | 1 | Renormalisation reached the all-ones exponent |

## Verification
Every result, including `out_valid`, is due one rising edge after the sample is accepted. The bench drives a sample on a falling edge and compares all outputs on the next falling edge, which is exactly one register stage later. Hold behaviour is checked the same way: the data inputs are changed with `in_valid` low, and the outputs are compared against the previous result one edge later. Directed carry, overflow and jamming cases are mixed with seeded random samples across all four policy codes.

// File: rtl/gt_pkg.sv
package gt_pkg;
  typedef enum logic [1:0] {
    POL_CHOP  = 2'd0,
    POL_JAM   = 2'd1,
    POL_ROUND = 2'd2,
    POL_SPARE = 2'd3
  } trunc_policy_e;
endpackage

// File: rtl/gt_policy.sv
module gt_policy
  import gt_pkg::*;
#(
  parameter int GUARD_W = 3
) (
  input  logic [1:0]         mode,
  input  logic [GUARD_W-1:0] guard,
  output logic               do_inc,
  output logic               do_jam,
  output logic               lost
);
  trunc_policy_e pol;

  always_comb begin
    pol    = trunc_policy_e'(mode);
    lost   = |guard;
    do_inc = 1'b0;
    do_jam = 1'b0;
    case (pol)
      POL_JAM:   do_jam = lost;
      POL_ROUND: do_inc = guard[GUARD_W-1];
      default:   begin
        do_inc = 1'b0;
        do_jam = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/gt_round_add.sv
module gt_round_add #(
  parameter int KEEP_W = 24
) (
  input  logic [KEEP_W-1:0] kept,
  input  logic              do_inc,
  input  logic              do_jam,
  output logic [KEEP_W-1:0] sum,
  output logic              carry
);
  logic [KEEP_W:0] wide;

  always_comb begin
    wide = {1'b0, kept} + {{KEEP_W{1'b0}}, do_inc};
    sum  = wide[KEEP_W-1:0];
    if (do_jam) sum[0] = 1'b1;
    carry = wide[KEEP_W];
  end
endmodule

// File: rtl/gt_renorm.sv
module gt_renorm #(
  parameter int KEEP_W = 24,
  parameter int EXP_W  = 8
) (
  input  logic [KEEP_W-1:0] sum,
  input  logic              carry,
  input  logic [EXP_W-1:0]  exp_in,
  output logic [KEEP_W-1:0] sig_n,
  output logic [EXP_W-1:0]  exp_n,
  output logic              ovf
);
  localparam logic [EXP_W-1:0] EXP_MAX  = '1;
  localparam logic [EXP_W-1:0] EXP_LAST = EXP_MAX - 1'b1;

  always_comb begin
    sig_n = sum;
    exp_n = exp_in;
    ovf   = 1'b0;
    if (carry) begin
      sig_n = {1'b1, sum[KEEP_W-1:1]};
      if (exp_in == EXP_LAST || exp_in == EXP_MAX) begin
        exp_n = EXP_MAX;
        ovf   = 1'b1;
      end else begin
        exp_n = exp_in + 1'b1;
      end
    end
  end
endmodule

// File: rtl/guard_trunc_unit.sv
module guard_trunc_unit #(
  parameter int FRAC_W  = 23,
  parameter int GUARD_W = 3,
  parameter int EXP_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [1:0]                 mode,
  input  logic [FRAC_W+GUARD_W:0]    sig_in,
  input  logic [EXP_W-1:0]           exp_in,
  output logic                       out_valid,
  output logic [FRAC_W:0]            sig_out,
  output logic [EXP_W-1:0]           exp_out,
  output logic                       inexact,
  output logic                       overflow
);
  localparam int KEEP_W = FRAC_W + 1;
  localparam int IN_W   = FRAC_W + GUARD_W + 1;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  logic [KEEP_W-1:0]  kept;
  logic [GUARD_W-1:0] guard;
  logic               do_inc, do_jam, lost;
  logic [KEEP_W-1:0]  sum;
  logic               carry;
  logic [KEEP_W-1:0]  sig_n;
  logic [EXP_W-1:0]   exp_n;
  logic               ovf_n;

  assign kept  = sig_in[IN_W-1:GUARD_W];
  assign guard = sig_in[GUARD_W-1:0];

  gt_policy #(.GUARD_W(GUARD_W)) u_policy (
    .mode   (mode),
    .guard  (guard),
    .do_inc (do_inc),
    .do_jam (do_jam),
    .lost   (lost)
  );

  gt_round_add #(.KEEP_W(KEEP_W)) u_add (
    .kept   (kept),
    .do_inc (do_inc),
    .do_jam (do_jam),
    .sum    (sum),
    .carry  (carry)
  );

  gt_renorm #(.KEEP_W(KEEP_W), .EXP_W(EXP_W)) u_renorm (
    .sum    (sum),
    .carry  (carry),
    .exp_in (exp_in),
    .sig_n  (sig_n),
    .exp_n  (exp_n),
    .ovf    (ovf_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sig_out   <= '0;
      exp_out   <= '0;
      inexact   <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sig_out  <= sig_n;
        exp_out  <= exp_n;
        inexact  <= lost;
        overflow <= ovf_n;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(sig_out) && $stable(exp_out) && $stable(inexact) && $stable(overflow)));

  // R10
  lead_one_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sig_in[IN_W-1]) |=> sig_out[FRAC_W]);

  // R8
  exact_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && guard == '0) |=> (!inexact && sig_out == $past(kept) && exp_out == $past(exp_in)));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (exp_out == EXP_MAX && sig_out[FRAC_W-1:0] == '0));

  // R3
  chop_exact_exp_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode != 2'd2) |=> (exp_out == $past(exp_in) && !overflow));
endmodule

// File: tb/sim_guard_trunc_unit.sv
module sim_guard_trunc_unit;
  localparam int FW = 23;
  localparam int GW = 3;
  localparam int EW = 8;
  localparam int KW = FW + 1;
  localparam int IW = FW + GW + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [1:0]    mode;
  logic [IW-1:0] sig_in;
  logic [EW-1:0] exp_in;
  logic          out_valid;
  logic [KW-1:0] sig_out;
  logic [EW-1:0] exp_out;
  logic          inexact, overflow;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  guard_trunc_unit #(.FRAC_W(FW), .GUARD_W(GW), .EXP_W(EW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .sig_in(sig_in), .exp_in(exp_in), .out_valid(out_valid),
    .sig_out(sig_out), .exp_out(exp_out), .inexact(inexact), .overflow(overflow)
  );

  // expected {sig, exp, inexact, overflow}
  function automatic logic [KW+EW+1:0] model(input logic [1:0] m,
                                              input logic [IW-1:0] s,
                                              input logic [EW-1:0] e);
    logic [KW-1:0] k;
    logic [GW-1:0] g;
    logic [KW:0]   w;
    logic [EW-1:0] eo;
    logic          ov;
    k  = s[IW-1:GW];
    g  = s[GW-1:0];
    w  = {1'b0, k};
    eo = e;
    ov = 1'b0;
    if (m == 2'd1 && g != 0) w[0] = 1'b1;
    if (m == 2'd2 && g[GW-1]) w = w + 1;
    if (w[KW]) begin
      w = w >> 1;
      if (e >= {EW{1'b1}} - 1) begin eo = '1; ov = 1'b1; end
      else eo = e + 1;
    end
    return {w[KW-1:0], eo, (g != 0), ov};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] m,
                     input logic [IW-1:0] s, input logic [EW-1:0] e);
    logic [KW+EW+1:0] x;
    x = model(m, s, e);
    @(negedge clk);
    in_valid = 1'b1; mode = m; sig_in = s; exp_in = e;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid R2"}, 64'(out_valid), 64'd1);
    check({req, " result"}, 64'({sig_out, exp_out, inexact, overflow}), 64'(x));
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [KW+EW+1:0] prev;
    int unsigned seed_dummy;
    rst = 1'b1; in_valid = 1'b0; mode = 0; sig_in = '0; exp_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", 64'({out_valid, sig_out, exp_out, inexact, overflow}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 64'({out_valid, sig_out, exp_out, inexact, overflow}), 64'd0);

    // R3 chop drops set guard bits; spare code 3 also chops
    run("R3 chop", 2'd0, {1'b1, 23'h000001, 3'b111}, 8'd100);
    check("R3 chop sig", 64'(sig_out), 64'h800001);
    run("R3 spare code", 2'd3, {1'b1, 23'h7FFFFF, 3'b100}, 8'd10);
    check("R3 spare sig", 64'(sig_out), 64'hFFFFFF);
    // R4 jamming
    run("R4 jam lsb", 2'd1, {1'b1, 23'h000010, 3'b001}, 8'd50);
    check("R4 jam sig", 64'(sig_out), 64'h800011);
    run("R4 jam exact", 2'd1, {1'b1, 23'h000010, 3'b000}, 8'd50);
    check("R8 exact", 64'(inexact), 64'd0);
    run("R4 jam set lsb", 2'd1, {1'b1, 23'h000003, 3'b010}, 8'd50);
    // R5 round-off
    run("R5 round up", 2'd2, {1'b1, 23'h000003, 3'b100}, 8'd70);
    check("R5 round sig", 64'(sig_out), 64'h800004);
    run("R5 round down", 2'd2, {1'b1, 23'h000003, 3'b011}, 8'd70);
    check("R5 chop sig", 64'(sig_out), 64'h800003);
    // R6 carry out renormalises
    run("R6 carry", 2'd2, {1'b1, 23'h7FFFFF, 3'b100}, 8'd20);
    check("R6 sig", 64'(sig_out), 64'h800000);
    check("R6 exp", 64'(exp_out), 64'd21);
    // R7 overflow edges
    run("R7 edge", 2'd2, {1'b1, 23'h7FFFFF, 3'b110}, 8'd253);
    check("R7 no ovf", 64'(overflow), 64'd0);
    run("R7 ovf", 2'd2, {1'b1, 23'h7FFFFF, 3'b101}, 8'd254);
    check("R7 ovf flag", 64'({exp_out, overflow}), 64'h1FF);
    run("R7 max in", 2'd2, {1'b1, 23'h7FFFFF, 3'b100}, 8'd255);
    // R8 inexact with chop
    run("R8 inexact", 2'd0, {1'b1, 23'h123456, 3'b010}, 8'd3);
    check("R8 flag", 64'(inexact), 64'd1);

    // R9 hold: change inputs with in_valid low
    prev = {sig_out, exp_out, inexact, overflow};
    @(negedge clk);
    in_valid = 1'b0; mode = 2'd2; sig_in = {1'b1, 23'h7FFFFF, 3'b111}; exp_in = 8'd254;
    @(negedge clk);
    check("R9 hold", 64'({sig_out, exp_out, inexact, overflow}), 64'(prev));
    check("R2 idle valid", 64'(out_valid), 64'd0);

    // R10 random normalised samples, all policies
    seed_dummy = $urandom(32'd1234);
    for (int i = 0; i < 300; i++) begin
      logic [IW-1:0] s;
      logic [EW-1:0] e;
      logic [1:0]    m;
      s = {1'b1, 23'($urandom), 3'($urandom)};
      if (i % 8 == 0) s[IW-2:GW] = '1;
      e = 8'($urandom);
      m = 2'($urandom);
      run("R10 random", m, s, e);
      check("R10 lead", 64'(sig_out[FW]), 64'd1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule